// File: doc/BRIEF.md
# Scrambled-Map Interrupt Controller

This block collects up to 64 active-low interrupt lines and presents them as register pairs: a high word and a low word for masking, and a high word and a low word for pending state. A vector number does not select a register bit directly. A fixed mapping scatters the vectors across the two words in an irregular bit order. Software reads one vector register to find the most urgent pending source that is not masked. A single request output tells the processor that some source needs service.

Each line belongs to one of three classes:
- Internal lines are always sensed as active-low levels.
- External lines are either active-low levels or falling-edge events.
- Port lines latch on both edges, or on the falling edge only.

A sense register selects between the two choices for the external and port lines. Edge events are held in pending until software writes 1 to clear them. Level sources always show the current synchronized line state. A plain 32-bit register bus with byte addresses reaches the mask, pending, sense and vector registers.

Top module: `vecmap_intc`

## Requirements
- R1: After reset both mask words, the sense register, both pending words and the vector readout are zero, and `irq_req` is low while all lines are held high.
- R2: Vectors 0–15 and 32–47 occupy the low mask and pending words. Vectors 16–31 and 48–63 occupy the high words. Vector 0 has no source, so low bit 0 of pending always reads 0.
- R3: The bit within a word is fixed as follows. Low word: vector v in 1–15 uses bit 16−v, and v in 32–47 uses bit 63−v. High word: v in 16–18 uses bit 18−v, v in 19–30 uses bit 33−v, vector 31 uses bit 15, and v in 48–63 uses bit v−32.
- R4: A mask bit of 1 enables its source and 0 blocks it. `irq_req` is high exactly when some pending bit and its mask bit are both 1.
- R5: For an edge-sensed source, writing 1 to its pending bit clears the latched event, and writing 0 leaves it unchanged. An edge detected in the same cycle as a clear wins.
- R6: Internal sources (all vectors from 1 to 63 outside 19–25 and 48–63), and external sources whose sense bit is 0, show the synchronized inverse of their line in pending. A write of 1 to such a bit has no lasting effect.
- R7: External sources 19–25 take their sense from sense bit 33−v, which covers bits 14 down to 8. A 1 selects falling-edge latching. A line held low then latches only once.
- R8: Port sources 48–63 take their sense from sense bit v−32. A 0 latches on both edges, and a 1 latches on the falling edge only.
- R9: The vector register carries the lowest-numbered source that is pending and unmasked in bits 31:26, and zeros elsewhere. A value of 0 means nothing is active. Reading it changes no state.
- R10: The byte offsets are: 0x00 high mask, 0x04 low mask, 0x08 high pending, 0x0C low pending, 0x10 sense, 0x14 vector. Writes to the vector register or to unlisted offsets change nothing. Unlisted offsets read 0. Sense bits outside 8–14 and 16–31 read 0.
- R11: A change on a line appears in pending within three clock edges (two synchronizer stages plus the edge latch).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_n | input | 64 | Active-low interrupt lines, bit v is vector v (bit 0 unused) |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, captured on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters:
- the external group is placed at vectors 19–25;
- the port group is placed at vectors 48–63;
- the synchronizer has two stages.

With these values, every vector from 1 to 63 can be driven one at a time and located in the scrambled word and bit map. The external group's level and falling-edge modes, and the port group's both-edge and falling-only modes, can each be exercised against the sense bit positions. Priority is tested both between two internal levels and between the two ends of the port group.

// File: rtl/vecmap_intc_pkg.sv
package vecmap_intc_pkg;

  localparam int NUM_VEC = 64;
  localparam int VEC_W   = $clog2(NUM_VEC);

  localparam int KIND_NONE = 0;
  localparam int KIND_INT  = 1;
  localparam int KIND_EXT  = 2;
  localparam int KIND_PORT = 3;

  localparam logic [7:0] OFF_MASK_HI = 8'h00;
  localparam logic [7:0] OFF_MASK_LO = 8'h04;
  localparam logic [7:0] OFF_PEND_HI = 8'h08;
  localparam logic [7:0] OFF_PEND_LO = 8'h0C;
  localparam logic [7:0] OFF_SENSE   = 8'h10;
  localparam logic [7:0] OFF_VECTOR  = 8'h14;

  // 1 when vector v lives in the high word
  function automatic logic vec_in_high(int v);
    return ((v / 16) % 2) == 1;
  endfunction

  // bit position of vector v inside its word
  function automatic int vec_bit(int v);
    if (v == 0)      return 0;
    else if (v < 16) return 16 - v;
    else if (v < 19) return 18 - v;
    else if (v < 31) return 33 - v;
    else if (v == 31) return 15;
    else if (v < 48) return 63 - v;
    else             return v - 32;
  endfunction

  function automatic int src_kind(int v, int ext_lo, int ext_hi, int port_lo, int port_hi);
    if (v == 0)                        return KIND_NONE;
    else if (v >= ext_lo && v <= ext_hi)   return KIND_EXT;
    else if (v >= port_lo && v <= port_hi) return KIND_PORT;
    else                               return KIND_INT;
  endfunction

  // sense register bit of a programmable source (0 for fixed ones)
  function automatic int sense_pos(int v, int ext_lo, int ext_hi, int port_lo, int port_hi);
    if (v >= ext_lo && v <= ext_hi)        return 14 - (v - ext_lo);
    else if (v >= port_lo && v <= port_hi) return 31 - (port_hi - v);
    else                                   return 0;
  endfunction

  function automatic logic [31:0] sense_impl(int ext_lo, int ext_hi, int port_lo, int port_hi);
    logic [31:0] m;
    m = '0;
    for (int v = 0; v < NUM_VEC; v++) begin
      if (src_kind(v, ext_lo, ext_hi, port_lo, port_hi) >= KIND_EXT)
        m[sense_pos(v, ext_lo, ext_hi, port_lo, port_hi)] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/vecmap_src_cond.sv
module vecmap_src_cond #(
  parameter int KIND        = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  input  logic sense_fall,
  input  logic clr,
  output logic pend
);
  import vecmap_intc_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q;
  logic latched_q;
  logic s;
  logic fall, rise;
  logic level_mode, edge_mode, edge_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_n};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign s    = sync_q[SYNC_STAGES-1];
  assign fall = prev_q & ~s;
  assign rise = ~prev_q & s;

  assign level_mode = (KIND == KIND_INT) || ((KIND == KIND_EXT) && !sense_fall);
  assign edge_mode  = ((KIND == KIND_EXT) && sense_fall) || (KIND == KIND_PORT);
  assign edge_hit   = ((KIND == KIND_EXT) && sense_fall && fall) ||
                      ((KIND == KIND_PORT) && (fall || (!sense_fall && rise)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          latched_q <= 1'b0;
    else if (!edge_mode) latched_q <= 1'b0;
    else if (edge_hit)   latched_q <= 1'b1;
    else if (clr)        latched_q <= 1'b0;
  end

  assign pend = (KIND == KIND_NONE) ? 1'b0 : (level_mode ? ~s : latched_q);

  // edge wins over a clear in the same cycle
  assert_edge_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_hit |=> (pend || !edge_mode));
  assert_clear_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !edge_hit && edge_mode) |=> (!pend || !edge_mode));
  assert_edge_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !edge_hit && !clr) |=> ($stable(pend) || !edge_mode));

endmodule

// File: rtl/vecmap_regs.sv
module vecmap_regs #(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 32,
  parameter int          VW         = 6,
  parameter logic [31:0] SENSE_MASK = 32'hFFFF_7F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pend_hi,
  input  logic [DATA_W-1:0] pend_lo,
  input  logic [VW-1:0]     vec_num,
  output logic [DATA_W-1:0] mask_hi,
  output logic [DATA_W-1:0] mask_lo,
  output logic [DATA_W-1:0] sense,
  output logic [DATA_W-1:0] clr_hi,
  output logic [DATA_W-1:0] clr_lo
);
  import vecmap_intc_pkg::*;

  logic hit_mhi, hit_mlo, hit_phi, hit_plo, hit_sns, hit_vec;

  assign hit_mhi = bus_addr == ADDR_W'(OFF_MASK_HI);
  assign hit_mlo = bus_addr == ADDR_W'(OFF_MASK_LO);
  assign hit_phi = bus_addr == ADDR_W'(OFF_PEND_HI);
  assign hit_plo = bus_addr == ADDR_W'(OFF_PEND_LO);
  assign hit_sns = bus_addr == ADDR_W'(OFF_SENSE);
  assign hit_vec = bus_addr == ADDR_W'(OFF_VECTOR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_hi <= '0;
      mask_lo <= '0;
      sense   <= '0;
    end else if (bus_wr) begin
      if (hit_mhi) mask_hi <= bus_wdata;
      if (hit_mlo) mask_lo <= bus_wdata;
      if (hit_sns) sense   <= bus_wdata & SENSE_MASK[DATA_W-1:0];
    end
  end

  assign clr_hi = (bus_wr && hit_phi) ? bus_wdata : '0;
  assign clr_lo = (bus_wr && hit_plo) ? bus_wdata : '0;

  always_comb begin
    bus_rdata = '0;
    if (hit_mhi)      bus_rdata = mask_hi;
    else if (hit_mlo) bus_rdata = mask_lo;
    else if (hit_phi) bus_rdata = pend_hi;
    else if (hit_plo) bus_rdata = pend_lo;
    else if (hit_sns) bus_rdata = sense;
    else if (hit_vec) bus_rdata = {vec_num, {(DATA_W-VW){1'b0}}};
  end

  assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_mhi) |=> (mask_hi == $past(bus_wdata)));
  assert_vec_readonly_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && hit_vec) |=> ($stable(mask_hi) && $stable(mask_lo) && $stable(sense)));

endmodule

// File: rtl/vecmap_prio.sv
module vecmap_prio #(
  parameter int NV = 64,
  parameter int VW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NV-1:0] active,
  output logic [VW-1:0] vec_num
);

  always_comb begin
    vec_num = '0;
    for (int v = NV - 1; v >= 1; v--) begin
      if (active[v]) vec_num = VW'(v);
    end
  end

  function automatic logic [NV-1:0] below(logic [VW-1:0] n);
    return (NV'(1) << n) - NV'(1);
  endfunction

  assert_vec_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_num != '0) |-> active[vec_num]);
  assert_vec_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((active & below(vec_num) & ~NV'(1)) == '0));

endmodule

// File: rtl/vecmap_intc.sv
module vecmap_intc #(
  parameter int ADDR_W      = 8,
  parameter int EXT_FIRST   = 19,
  parameter int EXT_LAST    = 25,
  parameter int PORT_FIRST  = 48,
  parameter int PORT_LAST   = 63,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [63:0]       src_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_req
);
  import vecmap_intc_pkg::*;

  localparam logic [31:0] SENSE_MASK = sense_impl(EXT_FIRST, EXT_LAST, PORT_FIRST, PORT_LAST);

  logic [31:0] mask_hi, mask_lo, sense_q, clr_hi, clr_lo, pend_hi, pend_lo;
  logic [NUM_VEC-1:0] mask_vec, clr_vec, sense_vec, pend_vec, active;
  logic [VEC_W-1:0] vec_num;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_src
    localparam int   KND = src_kind(v, EXT_FIRST, EXT_LAST, PORT_FIRST, PORT_LAST);
    localparam logic HI  = vec_in_high(v);
    localparam int   BP  = vec_bit(v);
    localparam int   SP  = sense_pos(v, EXT_FIRST, EXT_LAST, PORT_FIRST, PORT_LAST);

    assign mask_vec[v]  = HI ? mask_hi[BP] : mask_lo[BP];
    assign clr_vec[v]   = HI ? clr_hi[BP]  : clr_lo[BP];
    assign sense_vec[v] = (KND >= KIND_EXT) ? sense_q[SP] : 1'b0;

    vecmap_src_cond #(.KIND(KND), .SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .line_n(src_n[v]),
      .sense_fall(sense_vec[v]), .clr(clr_vec[v]), .pend(pend_vec[v])
    );

    if (HI) begin : g_hi
      assign pend_hi[BP] = pend_vec[v];
    end else begin : g_lo
      assign pend_lo[BP] = pend_vec[v];
    end
  end

  assign active  = pend_vec & mask_vec;
  assign irq_req = |active;

  vecmap_prio #(.NV(NUM_VEC), .VW(VEC_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .active(active), .vec_num(vec_num)
  );

  vecmap_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .VW(VEC_W), .SENSE_MASK(SENSE_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_hi(pend_hi), .pend_lo(pend_lo), .vec_num(vec_num),
    .mask_hi(mask_hi), .mask_lo(mask_lo), .sense(sense_q),
    .clr_hi(clr_hi), .clr_lo(clr_lo)
  );

  // request and encoder come from separate logic; they must agree
  assert_req_matches_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (vec_num != '0));
  assert_pend_lo0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_lo[0]);

endmodule

// File: tb/tb_vecmap_intc.sv
module tb_vecmap_intc;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, bus_wr = 0, irq_req;
  logic [63:0] src_n = '1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, failures = 0;
  logic [31:0] mhi = 0, mlo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vecmap_intc dut (.clk(clk), .rst_n(rst_n), .src_n(src_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req));

  function automatic logic exp_high(int v);
    return ((v >> 4) & 1) == 1;
  endfunction

  function automatic int exp_bit(int v);
    if (!exp_high(v)) return (v < 16) ? ((16 - v) & 15) : (63 - v);
    if (v <= 18) return 18 - v;
    if (v <= 30) return 33 - v;
    if (v == 31) return 15;
    return v - 32;
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_mask(int v, logic on);
    if (exp_high(v)) begin mhi[exp_bit(v)] = on; wr(8'h00, mhi); end
    else begin mlo[exp_bit(v)] = on; wr(8'h04, mlo); end
  endtask

  task automatic clear_pend(int v);
    wr(exp_high(v) ? 8'h08 : 8'h0C, 32'h1 << exp_bit(v));
  endtask

  task automatic check_pend(int v, logic set, string tag);
    logic [31:0] hi, lo, one;
    one = set ? (32'h1 << exp_bit(v)) : 32'h0;
    rd(8'h08, hi); rd(8'h0C, lo);
    chk(hi, exp_high(v) ? one : 32'h0, tag);
    chk(lo, exp_high(v) ? 32'h0 : one, tag);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int a = 0; a <= 8'h14; a += 4) begin
      rd(8'(a), d); chk(d, 32'h0, "R1 reset register");
    end
    chk({31'b0, irq_req}, 0, "R1 reset irq_req");
  endtask

  task automatic t_map();
    for (int v = 1; v < 64; v++) begin
      src_n[v] = 0; settle();
      check_pend(v, 1, $sformatf("R2 R3 R11 vector %0d", v));
      src_n[v] = 1; settle();
      if (v >= 48) begin
        clear_pend(v);
        check_pend(v, 0, $sformatf("R5 port clear vector %0d", v));
      end else begin
        check_pend(v, 0, $sformatf("R6 level release vector %0d", v));
      end
    end
  endtask

  task automatic t_mask_prio();
    logic [31:0] d, d2;
    src_n[40] = 0; src_n[7] = 0; settle();
    rd(8'h14, d); chk(d, 0, "R4 all masked vector");
    chk({31'b0, irq_req}, 0, "R4 all masked irq");
    set_mask(40, 1); rd(8'h14, d);
    chk(d, 32'(40) << 26, "R9 vector 40");
    chk({31'b0, irq_req}, 1, "R4 irq on unmask");
    set_mask(7, 1); rd(8'h14, d); rd(8'h14, d2);
    chk(d, 32'(7) << 26, "R9 lower wins");
    chk(d2, 32'(7) << 26, "R9 read no side effect");
    set_mask(7, 0); rd(8'h14, d);
    chk(d, 32'(40) << 26, "R4 masked 7 skipped");
    set_mask(40, 0);
    src_n[40] = 1; src_n[7] = 1; settle();
  endtask

  task automatic t_level_w1c();
    src_n[5] = 0; settle();
    clear_pend(5);
    check_pend(5, 1, "R6 level write-1 no effect");
    src_n[5] = 1; settle();
  endtask

  task automatic t_ext_edge();
    logic [31:0] d;
    wr(8'h10, 32'h1 << 12);
    src_n[21] = 0; repeat (3) @(negedge clk); src_n[21] = 1; settle();
    check_pend(21, 1, "R7 falling latched");
    wr(8'h08, 32'h0);
    check_pend(21, 1, "R5 write 0 no effect");
    clear_pend(21);
    check_pend(21, 0, "R5 write 1 clears");
    src_n[21] = 0; settle(); clear_pend(21); settle();
    check_pend(21, 0, "R7 held low latches once");
    src_n[21] = 1; settle();
    check_pend(21, 0, "R7 rising ignored");
    wr(8'h10, 0);
    rd(8'h10, d); chk(d, 0, "R10 sense cleared");
  endtask

  task automatic t_port();
    src_n[50] = 0; settle(); clear_pend(50);
    src_n[50] = 1; settle();
    check_pend(50, 1, "R8 both-edge rising");
    clear_pend(50);
    wr(8'h10, 32'h1 << 18);
    src_n[50] = 0; settle();
    check_pend(50, 1, "R8 falling-only falling");
    clear_pend(50);
    src_n[50] = 1; settle();
    check_pend(50, 0, "R8 falling-only rising ignored");
    wr(8'h10, 0);
  endtask

  task automatic t_port_prio();
    logic [31:0] d;
    set_mask(48, 1); set_mask(63, 1);
    src_n[48] = 0; src_n[63] = 0; settle();
    rd(8'h14, d); chk(d, 32'(48) << 26, "R9 port 48 first");
    clear_pend(48);
    rd(8'h14, d); chk(d, 32'(63) << 26, "R9 port 63 after clear");
    set_mask(48, 0); set_mask(63, 0);
    src_n[48] = 1; src_n[63] = 1; settle();
    clear_pend(48); clear_pend(63);
    rd(8'h14, d); chk(d, 0, "R9 none active");
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h00, d); chk(d, 0, "R10 vector write ignored hi");
    rd(8'h04, d); chk(d, 0, "R10 vector write ignored lo");
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); chk(d, 0, "R10 unlisted reads 0");
    rd(8'h10, d); chk(d, 0, "R10 unlisted write ignored");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk(d, 32'hFFFF_7F00, "R10 sense implemented bits");
    wr(8'h10, 0);
    wr(8'h00, 32'hA5A5_0001);
    rd(8'h00, d); chk(d, 32'hA5A5_0001, "R4 mask write hi");
    wr(8'h00, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_map();
    t_mask_prio();
    t_level_w1c();
    t_ext_edge();
    t_port();
    t_port_prio();
    t_regmap();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule